// File: doc/BRIEF.md
# Speed-Loop Phase Comparator with Lock Detector

This block sits in the speed loop of a motor controller. It compares a reference clock with the motor's tachometer (FG) signal and drives a charge-pump style correction. The reference comes in on its own input. An on-chip divider turns a crystal-rate enable into a divided clock. That divided clock is brought out on a separate pin, so the system can wire it straight back to the reference input or place an external divider between the two.

The comparator is a three-state phase-frequency detector. A falling reference edge raises the pump-up output and a qualified FG edge raises pump-down. When both are set, both clear in the same cycle. The width of the pulse therefore equals the time between the two edges, counted in system clock cycles. The FG qualifier accepts either falling edges only or both edges. In the both-edges setting the FG rate the loop settles to is half the reference rate.

A lock flag is computed from edge coincidence alone; speed error is not used. The flag sets after a run of consecutive comparisons that each fall within a programmable tolerance. It clears on the first comparison that falls outside that tolerance, and also when a pump pulse grows to the limit of the width counter without its matching edge arriving. A second output always carries the inverse of the flag.

Top module: `spdPhaseLock`

## Requirements
- R1: The divider counts `xtalTick` pulses. `divSel` 0 gives a period of DIV_LO (3072) ticks, 1 gives DIV_MID (1024), and 2 or 3 gives DIV_HI (4096). `divClkOut` is high for the first half of each period and is 1 after reset.
- R2: The divider state and `divClkOut` do not change in any cycle where `xtalTick` is low.
- R3: Only falling edges of `refIn` start or end a comparison. A rising edge of `refIn` has no effect on `pumpUp` or `pumpDn`.
- R4: With `fgBothEdges` = 0, only falling edges of `fgIn` count, and rising edges are ignored.
- R5: With `fgBothEdges` = 1, both rising and falling edges of `fgIn` count as FG edges.
- R6: When the reference edge leads the FG edge by d cycles, `pumpUp` is high for exactly d cycles and `pumpDn` stays low.
- R7: When the FG edge leads the reference edge by d cycles, `pumpDn` is high for exactly d cycles and `pumpUp` stays low.
- R8: `pumpUp` and `pumpDn` are never high in the same cycle. Edges that coincide produce no pulse on either output.
- R9: `locked` rises after LOCK_CNT (8) consecutive comparisons whose width is less than or equal to `lockTol`. A width equal to `lockTol` counts as within tolerance.
- R10: One comparison whose width exceeds `lockTol` clears `locked` and restarts the count.
- R11: If a pump pulse stays high until the width counter saturates at 2^ERR_W-1 cycles, `locked` clears while the pulse continues.
- R12: `notLocked` is always the inverse of `locked`. After reset, both pumps are low and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xtalTick | input | 1 | One-cycle enable at the crystal rate |
| divSel | input | 2 | Divisor select: 0 = 3072, 1 = 1024, 2 or 3 = 4096 |
| fgBothEdges | input | 1 | 0 = falling FG edges only, 1 = both FG edges |
| refIn | input | 1 | Comparator reference input (asynchronous) |
| fgIn | input | 1 | Tachometer input (asynchronous) |
| lockTol | input | ERR_W | Lock tolerance in clock cycles |
| divClkOut | output | 1 | Divided crystal clock |
| pumpUp | output | 1 | Pulse while the reference edge leads |
| pumpDn | output | 1 | Pulse while the FG edge leads |
| locked | output | 1 | Phase lock flag |
| notLocked | output | 1 | Inverse of the lock flag |

## Verification
The embedded properties check on every cycle that the two pumps never overlap and that a pump rises only after its own edge strobe. They also check that the divider holds still without a tick, that `locked` changes only at a comparison or a saturation event, and that it rises only after the full run of in-tolerance comparisons. Behaviour that depends on a whole stimulus pattern can only be shown by the directed scenarios: the exact pulse widths for leads of various lengths, the effect of the FG edge setting, the divider periods for each select value, the tolerance boundary, and the drop on saturation.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Strobes passed from the edge/state control to the measuring datapath
  typedef struct packed {
    logic refFall;   // qualified falling reference edge this cycle
    logic fgEdge;    // qualified FG edge this cycle
    logic cmpDone;   // both sides seen: comparison completes this cycle
  } splStrobe_t;
endpackage

// File: rtl/spl_refDivider.sv
module spl_refDivider #(
  parameter int DIV_LO  = 3072,
  parameter int DIV_MID = 1024,
  parameter int DIV_HI  = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalTick,
  input  logic [1:0] divSel,
  output logic       divClk
);
  localparam int MAX_A  = (DIV_LO > DIV_MID) ? DIV_LO : DIV_MID;
  localparam int MAXDIV = (MAX_A > DIV_HI) ? MAX_A : DIV_HI;
  localparam int CNT_W  = $clog2(MAXDIV);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   curDiv;
  logic [CNT_W:0]   halfDiv;
  logic             atEnd;

  always_comb begin
    unique case (divSel)
      2'd0:    curDiv = (CNT_W+1)'(DIV_LO);
      2'd1:    curDiv = (CNT_W+1)'(DIV_MID);
      default: curDiv = (CNT_W+1)'(DIV_HI);
    endcase
  end

  assign halfDiv = curDiv >> 1;
  assign atEnd   = ({1'b0, cnt} >= (curDiv - 1'b1));
  assign divClk  = ({1'b0, cnt} < halfDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (xtalTick) cnt <= atEnd ? '0 : cnt + 1'b1;
  end

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xtalTick |=> $stable(cnt));
endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
  import spl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       fgIn,
  input  logic       fgBothEdges,
  output splStrobe_t strb,
  output logic       pumpUp,
  output logic       pumpDn
);
  logic refMeta, refSync, refPrev;
  logic fgMeta, fgSync, fgPrev;
  logic modeMeta, modeSync;
  logic refFall, fgEdge, upNext, dnNext, bothSet;

  // Synchronizers run freely so that reset release creates no false edge
  always_ff @(posedge clk) begin
    refMeta  <= refIn;
    refSync  <= refMeta;
    refPrev  <= refSync;
    fgMeta   <= fgIn;
    fgSync   <= fgMeta;
    fgPrev   <= fgSync;
    modeMeta <= fgBothEdges;
    modeSync <= modeMeta;
  end

  assign refFall = refPrev & ~refSync;
  assign fgEdge  = modeSync ? (fgPrev ^ fgSync) : (fgPrev & ~fgSync);
  assign upNext  = pumpUp | refFall;
  assign dnNext  = pumpDn | fgEdge;
  assign bothSet = upNext & dnNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pumpUp <= 1'b0;
      pumpDn <= 1'b0;
    end else if (bothSet) begin
      pumpUp <= 1'b0;
      pumpDn <= 1'b0;
    end else begin
      pumpUp <= upNext;
      pumpDn <= dnNext;
    end
  end

  always_comb begin
    strb.refFall = refFall;
    strb.fgEdge  = fgEdge;
    strb.cmpDone = bothSet;
  end

  // R8
  pump_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDn));
  // R3
  up_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpUp) |-> $past(refFall));
  // R4
  dn_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpDn) |-> $past(fgEdge));
endmodule

// File: rtl/spl_datapath.sv
module spl_datapath
  import spl_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int LOCK_CNT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  splStrobe_t       strb,
  input  logic             pumpUp,
  input  logic             pumpDn,
  input  logic [ERR_W-1:0] lockTol,
  output logic             locked
);
  localparam int STREAK_W = $clog2(LOCK_CNT + 1);

  logic [ERR_W-1:0]    errCnt;
  logic [ERR_W:0]      width;
  logic [STREAK_W-1:0] streak;
  logic                pumpOn, errSat, inTol;

  assign pumpOn = pumpUp | pumpDn;
  assign errSat = &errCnt;
  assign width  = {1'b0, errCnt} + {{ERR_W{1'b0}}, pumpOn};
  assign inTol  = width <= {1'b0, lockTol};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                errCnt <= '0;
    else if (strb.cmpDone)    errCnt <= '0;
    else if (pumpOn && !errSat) errCnt <= errCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streak <= '0;
      locked <= 1'b0;
    end else if (errSat) begin
      streak <= '0;
      locked <= 1'b0;
    end else if (strb.cmpDone) begin
      if (inTol) begin
        if (streak != STREAK_W'(LOCK_CNT)) streak <= streak + 1'b1;
        locked <= (streak >= STREAK_W'(LOCK_CNT - 1));
      end else begin
        streak <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(strb.cmpDone || errSat));
  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(strb.cmpDone) && $past(streak) == STREAK_W'(LOCK_CNT - 1)));
  // R8
  cmp_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmpDone |-> (strb.refFall || pumpUp) && (strb.fgEdge || pumpDn));
endmodule

// File: rtl/spdPhaseLock.sv
module spdPhaseLock
  import spl_pkg::*;
#(
  parameter int DIV_LO   = 3072,
  parameter int DIV_MID  = 1024,
  parameter int DIV_HI   = 4096,
  parameter int ERR_W    = 16,
  parameter int LOCK_CNT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalTick,
  input  logic [1:0]       divSel,
  input  logic             fgBothEdges,
  input  logic             refIn,
  input  logic             fgIn,
  input  logic [ERR_W-1:0] lockTol,
  output logic             divClkOut,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             locked,
  output logic             notLocked
);
  splStrobe_t strb;

  spl_refDivider #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) uDiv (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .divSel(divSel), .divClk(divClkOut));

  spl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fgIn(fgIn), .fgBothEdges(fgBothEdges),
    .strb(strb), .pumpUp(pumpUp), .pumpDn(pumpDn));

  spl_datapath #(.ERR_W(ERR_W), .LOCK_CNT(LOCK_CNT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .lockTol(lockTol), .locked(locked));

  assign notLocked = ~locked;

  // R12
  lock_inverse_chk: assert property (@(posedge clk) notLocked != locked);
endmodule

// File: tb/tb_spdPhaseLock.sv
module tb_spdPhaseLock;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xtalTick = 1'b0;
  logic [1:0] divSel = 2'd1;
  logic fgBothEdges = 1'b0;
  logic refIn = 1'b1;
  logic fgIn = 1'b1;
  logic [ERR_W-1:0] lockTol = 8'd2;
  logic divClkOut, pumpUp, pumpDn, locked, notLocked;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  spdPhaseLock #(.ERR_W(ERR_W)) dut (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .divSel(divSel),
    .fgBothEdges(fgBothEdges), .refIn(refIn), .fgIn(fgIn), .lockTol(lockTol),
    .divClkOut(divClkOut), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .locked(locked), .notLocked(notLocked));

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(bit bothMode, bit fgIdle);
    @(negedge clk);
    rstN = 1'b0;
    fgBothEdges = bothMode;
    refIn = 1'b1;
    fgIn = fgIdle;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic driveFg();
    fgIn = fgBothEdges ? ~fgIn : 1'b0;
  endtask

  // One comparison: leading side first, other side d cycles later
  task automatic runPair(bit refFirst, int d, output int upW, output int dnW);
    upW = 0; dnW = 0;
    @(negedge clk);
    if (refFirst || d == 0) refIn = 1'b0;
    if (!refFirst || d == 0) driveFg();
    for (int i = 0; i < d + 12; i++) begin
      if (pumpUp) upW++;
      if (pumpDn) dnW++;
      @(negedge clk);
      if (i == d - 1) begin
        if (refFirst) driveFg(); else refIn = 1'b0;
      end
    end
    refIn = 1'b1;
    if (!fgBothEdges) fgIn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (pumpUp) upW++;
      if (pumpDn) dnW++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b1);
    chk("R12 reset pumpUp", int'(pumpUp), 0);
    chk("R12 reset pumpDn", int'(pumpDn), 0);
    chk("R12 reset locked", int'(locked), 0);
    chk("R12 reset notLocked", int'(notLocked), 1);
    chk("R1 reset divClkOut", int'(divClkOut), 1);
  endtask

  task automatic measurePeriod(logic [1:0] sel, int every, int expPeriod, string req);
    int cyc = 0, rises = 0, t2 = 0, t3 = 0;
    logic prev;
    divSel = sel;
    prev = divClkOut;
    while (rises < 3 && cyc < 40000) begin
      xtalTick = ((cyc % every) == 0);
      @(negedge clk);
      cyc++;
      if (divClkOut && !prev) begin
        rises++;
        if (rises == 2) t2 = cyc;
        if (rises == 3) t3 = cyc;
      end
      prev = divClkOut;
    end
    xtalTick = 1'b0;
    chk(req, t3 - t2, expPeriod);
  endtask

  task automatic testDivider();
    int toggles = 0;
    logic prev;
    measurePeriod(2'd1, 1, 1024, "R1 divide mid");
    measurePeriod(2'd0, 1, 3072, "R1 divide low");
    measurePeriod(2'd2, 1, 4096, "R1 divide high");
    measurePeriod(2'd3, 1, 4096, "R1 divide undriven");
    measurePeriod(2'd1, 2, 2048, "R2 tick every other cycle");
    xtalTick = 1'b0;
    prev = divClkOut;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (divClkOut != prev) toggles++;
      prev = divClkOut;
    end
    chk("R2 no tick no change", toggles, 0);
  endtask

  task automatic testPulses();
    int u, d;
    doReset(1'b0, 1'b1);
    runPair(1'b1, 7, u, d);
    chk("R6 up width ref leads 7", u, 7);
    chk("R6 no down when ref leads", d, 0);
    runPair(1'b1, 1, u, d);
    chk("R6 up width ref leads 1", u, 1);
    runPair(1'b0, 5, u, d);
    chk("R7 down width fg leads 5", d, 5);
    chk("R7 no up when fg leads", u, 0);
    runPair(1'b1, 0, u, d);
    chk("R8 coincident up", u, 0);
    chk("R8 coincident down", d, 0);
    // R3: rising reference edge alone
    @(negedge clk); refIn = 1'b0;
    doReset(1'b0, 1'b1);
    refIn = 1'b0;
    repeat (6) @(negedge clk);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    refIn = 1'b1;
    u = 0; d = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pumpUp) u++;
      if (pumpDn) d++;
    end
    chk("R3 ref rise ignored up", u, 0);
    chk("R3 ref rise ignored down", d, 0);
  endtask

  task automatic testEdgeMode(bit both);
    int u = 0;
    doReset(both, 1'b0);
    @(negedge clk);
    refIn = 1'b0;
    for (int i = 0; i < 22; i++) begin
      if (pumpUp) u++;
      @(negedge clk);
      if (i == 3) fgIn = 1'b1;
      if (i == 9) fgIn = 1'b0;
    end
    if (both) begin
      chk("R5 fg rise ends up pulse", u, 4);
      chk("R5 fg fall starts down", int'(pumpDn), 1);
    end else begin
      chk("R4 fg rise ignored up width", u, 10);
      chk("R4 no down pulse", int'(pumpDn), 0);
    end
  endtask

  task automatic testLock();
    int u, d;
    doReset(1'b0, 1'b1);
    lockTol = 8'd2;
    for (int k = 0; k < 7; k++) runPair(1'b1, 1, u, d);
    chk("R9 not locked after 7", int'(locked), 0);
    runPair(1'b1, 1, u, d);
    chk("R9 locked after 8", int'(locked), 1);
    chk("R12 notLocked inverse", int'(notLocked), 0);
    runPair(1'b0, 3, u, d);
    chk("R10 unlock outside tolerance", int'(locked), 0);
    chk("R12 notLocked after unlock", int'(notLocked), 1);
    for (int k = 0; k < 7; k++) runPair(1'b1, 2, u, d);
    chk("R10 count restarted", int'(locked), 0);
    runPair(1'b0, 2, u, d);
    chk("R9 width equal tolerance locks", int'(locked), 1);
  endtask

  task automatic testSaturate();
    @(negedge clk);
    refIn = 1'b0;
    repeat (300) @(negedge clk);
    chk("R11 saturation unlocks", int'(locked), 0);
    chk("R11 pulse continues", int'(pumpUp), 1);
    fgIn = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 late fg edge ends pulse", int'(pumpUp), 0);
    refIn = 1'b1; fgIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    testReset();
    testDivider();
    testPulses();
    testEdgeMode(1'b0);
    testEdgeMode(1'b1);
    testLock();
    testSaturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1500000;
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule